// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the register side of a 10/100 Ethernet PHY as seen from a MAC's management port. It holds sixteen 16-bit registers with fixed power-up contents, two identifier registers and a status register that software cannot overwrite, and a control register whose top bit reloads the whole bank. A link input keeps the status link bit and the partner-ability bits current.

The MAC side writes three registers through strobes sharing one data bus. These are an address word (PHY address and register address), a write-data register and a command register. A read command loads the selected PHY register into a held read-data output and samples the link into a link-fail flag. A write command, or a write to the write-data register, stores data into the selected register. Only one PHY address is answered. The scan bit makes the link-fail flag follow the link on its own. Serial bit timing and real negotiation are not modelled.

Top module: `mgmt_phy_regbank`

## Requirements
- R1: After reset the registers read: index 0 = 0x1000, index 1 = 0x7868, index 2 = 0x2000, index 3 = 0x5C90, index 4 = 0x01E1, every other index = 0x0000 (link down). rd_data, link_fail and done are 0.
- R2: Writing index 0 with bit 15 set does not store the value. It reloads every register to its R1 value, with the link effects of R4 applied for the current link level. Without bit 15 the value is stored unchanged.
- R3: Writes to indices 1, 2 and 3 are ignored. Every other index from 0 to 15 stores the written 16-bit value.
- R4: On a link rise, bit 2 of index 1 sets and index 5 is ORed with 0x01E1. On a link fall, bit 2 of index 1 clears and index 5 is ANDed with 0x01FF. Each takes effect at the first clock edge that sees the new level.
- R5: An address word strobe takes the register address from wr_data[12:8] and the PHY address from wr_data[4:0]. Register writes and reads are answered only when the PHY address is 1. Writes to any other PHY address leave the bank unchanged.
- R6: A read to a PHY address other than 1 returns 0xFFFF. A read of PHY 1 at register address 16 to 31 returns 0x0000, and writes there are ignored.
- R7: Every read command sets link_fail to the inverse of link_up.
- R8: A write-data strobe latches wr_data and, when the PHY address is 1, writes it to the selected register at once. A command with wr_data[2] set writes the latched data. Command bit 1 is read and bit 0 is scan.
- R9: While the stored scan bit is 1, each link change sets link_fail to the new inverse link level at the same edge. While it is 0, link changes leave link_fail unchanged.
- R10: done is high for exactly the one cycle after any strobe. rd_data holds its value until the next read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Line link level |
| addr_wr | input | 1 | Load address word from wr_data |
| data_wr | input | 1 | Load write-data register from wr_data |
| cmd_wr | input | 1 | Issue command from wr_data[2:0] |
| wr_data | input | 16 | MAC-side write bus |
| rd_data | output | 16 | Read-data register |
| link_fail | output | 1 | Link-fail status flag |
| done | output | 1 | One-cycle access completion pulse |

## Verification
The bank is read back after reset, after plain writes, after writes to the protected and out-of-range indices, and after a soft reset with non-default contents in place. This separates a missing reload from a partial one. Writes through the data strobe and through the write command are each tried, with the PHY address both matching and not. That exposes a wrong data source or a missing address filter. The link is toggled with a non-zero partner value already stored, so OR and AND masking are told apart. Link-fail is followed with scan both off and on, so reads and automatic tracking can be checked separately.

// File: rtl/mgmt_phy_regbank.sv
module mgmt_phy_regbank #(
  parameter int         NREG    = 16,
  parameter int         RAW     = 5,
  parameter int         PAW     = 5,
  parameter logic [4:0] OWN_PHY = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        addr_wr,
  input  logic        data_wr,
  input  logic        cmd_wr,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        link_fail,
  output logic        done
);
  localparam int          IW       = $clog2(NREG);
  localparam logic [15:0] ABIL     = 16'h01E1;
  localparam logic [15:0] LINK_BIT = 16'h0004;

  logic [15:0]    regs [NREG];
  logic [15:0]    tx_q;
  logic [PAW-1:0] phy_q;
  logic [RAW-1:0] ra_q;
  logic           scan_q, link_q;

  function automatic logic [15:0] dflt(input int i);
    case (i)
      0:       return 16'h1000;
      1:       return 16'h7868;
      2:       return 16'h2000;
      3:       return 16'h5C90;
      4:       return ABIL;
      default: return 16'h0000;
    endcase
  endfunction

  wire [15:0]   wr_val   = data_wr ? wr_data : tx_q;
  wire          hit      = phy_q == OWN_PHY[PAW-1:0];
  wire          in_range = ra_q < NREG;
  wire [IW-1:0] idx      = ra_q[IW-1:0];
  wire          do_wr    = (data_wr || (cmd_wr && wr_data[2])) && hit && in_range;
  wire          soft_rst = do_wr && idx == 0 && wr_val[15];
  wire          prot     = idx == 1 || idx == 2 || idx == 3;
  wire          link_chg = link_q != link_up;
  wire          rd_cmd   = cmd_wr && wr_data[1];
  wire [15:0]   sel      = in_range ? regs[idx] : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
      link_q <= 1'b0;
    end else begin
      link_q <= link_up;
      if (soft_rst) begin
        for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
        regs[1] <= link_up ? (dflt(1) | LINK_BIT) : dflt(1);
        regs[5] <= link_up ? ABIL : 16'h0000;
      end else begin
        if (do_wr && !prot) regs[idx] <= wr_val;
        if (link_chg) begin
          regs[1] <= link_up ? (regs[1] | LINK_BIT) : (regs[1] & ~LINK_BIT);
          regs[5] <= link_up ? (regs[5] | ABIL) : (regs[5] & 16'h01FF);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0; phy_q <= '0; ra_q <= '0; scan_q <= 1'b0;
      rd_data <= '0; link_fail <= 1'b0; done <= 1'b0;
    end else begin
      done <= addr_wr || data_wr || cmd_wr;
      if (addr_wr) begin
        ra_q  <= wr_data[8 +: RAW];
        phy_q <= wr_data[PAW-1:0];
      end
      if (data_wr) tx_q <= wr_data;
      if (cmd_wr) scan_q <= wr_data[0];
      if (rd_cmd) rd_data <= hit ? sel : 16'hFFFF;
      if (rd_cmd) link_fail <= !link_up;
      else if (scan_q && link_chg) link_fail <= !link_up;
    end
  end

  p_ident_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(regs[2]) && $stable(regs[3]));
  p_status_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg && !soft_rst |=> regs[1][2] == $past(link_up));
  p_foreign_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && !hit |=> rd_data == 16'hFFFF);
  p_read_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> link_fail == !$past(link_up));
  p_scan_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_q && link_chg && !rd_cmd |=> link_fail == !$past(link_up));
  p_noscan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_q && !rd_cmd |=> $stable(link_fail));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> $stable(rd_data));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(addr_wr || data_wr || cmd_wr));
endmodule

// File: tb/mgmt_phy_regbank_tb.sv
module mgmt_phy_regbank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, link_up = 1'b0;
  logic addr_wr = 1'b0, data_wr = 1'b0, cmd_wr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic link_fail, done;
  int checks = 0, fails = 0;
  logic scan_on = 1'b0;

  always #4 clk = ~clk;

  mgmt_phy_regbank dut_i (.clk, .rst_n, .link_up, .addr_wr, .data_wr, .cmd_wr,
                          .wr_data, .rd_data, .link_fail, .done);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe(int kind, logic [15:0] v);
    @(negedge clk);
    wr_data = v;
    addr_wr = (kind == 0); data_wr = (kind == 1); cmd_wr = (kind == 2);
    @(negedge clk);
    addr_wr = 0; data_wr = 0; cmd_wr = 0;
  endtask

  task automatic set_addr(int phy, int ra);
    strobe(0, 16'((ra << 8) | phy));
  endtask

  task automatic rd(int phy, int ra, output logic [15:0] v);
    set_addr(phy, ra);
    strobe(2, {13'd0, 2'b01, scan_on});
    v = rd_data;
  endtask

  task automatic wr_cmd(int phy, int ra, logic [15:0] v);
    strobe(1, v);
    set_addr(phy, ra);
    strobe(2, {13'd0, 2'b10, scan_on});
  endtask

  task automatic wr_direct(int phy, int ra, logic [15:0] v);
    set_addr(phy, ra);
    strobe(1, v);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 link_fail", {15'd0, link_fail}, 16'h0);
    chk("R1 done", {15'd0, done}, 16'h0);
    rd(1, 0, v); chk("R1 reg0", v, 16'h1000);
    rd(1, 1, v); chk("R1 reg1", v, 16'h7868);
    rd(1, 2, v); chk("R1 reg2", v, 16'h2000);
    rd(1, 3, v); chk("R1 reg3", v, 16'h5C90);
    rd(1, 4, v); chk("R1 reg4", v, 16'h01E1);
    rd(1, 5, v); chk("R1 reg5", v, 16'h0000);
    rd(1, 15, v); chk("R1 reg15", v, 16'h0000);
  endtask

  task automatic t_link;
    logic [15:0] v;
    link_up = 1; wait_cyc(2);
    rd(1, 1, v); chk("R4 status up", v, 16'h786C);
    rd(1, 5, v); chk("R4 partner up", v, 16'h01E1);
    wr_direct(1, 5, 16'h0E12);
    link_up = 0; wait_cyc(2);
    rd(1, 1, v); chk("R4 status down", v, 16'h7868);
    rd(1, 5, v); chk("R4 partner mask", v, 16'h0012);
    link_up = 1; wait_cyc(2);
    rd(1, 5, v); chk("R4 partner or", v, 16'h01F3);
  endtask

  task automatic t_readonly;
    logic [15:0] v;
    wr_cmd(1, 1, 16'hAAAA); wr_cmd(1, 2, 16'hAAAA); wr_cmd(1, 3, 16'hAAAA);
    rd(1, 1, v); chk("R3 status ro", v, 16'h786C);
    rd(1, 2, v); chk("R3 id1 ro", v, 16'h2000);
    rd(1, 3, v); chk("R3 id2 ro", v, 16'h5C90);
    wr_cmd(1, 7, 16'h1234);
    rd(1, 7, v); chk("R3 plain rw", v, 16'h1234);
  endtask

  task automatic t_phyaddr;
    logic [15:0] v;
    wr_direct(2, 7, 16'h5555);
    wr_cmd(0, 7, 16'h6666);
    rd(1, 7, v); chk("R5 foreign write ignored", v, 16'h1234);
    rd(2, 7, v); chk("R6 foreign read phy2", v, 16'hFFFF);
    rd(0, 0, v); chk("R6 foreign read phy0", v, 16'hFFFF);
    wr_cmd(1, 20, 16'h7777);
    rd(1, 20, v); chk("R6 out of range", v, 16'h0000);
  endtask

  task automatic t_wdata;
    logic [15:0] v;
    wr_direct(1, 9, 16'hBEEF);
    rd(1, 9, v); chk("R8 direct write", v, 16'hBEEF);
    wr_direct(3, 10, 16'hC0DE);
    rd(1, 10, v); chk("R8 no write before cmd", v, 16'h0000);
    set_addr(1, 10);
    strobe(2, {13'd0, 2'b10, scan_on});
    rd(1, 10, v); chk("R8 cmd write latched data", v, 16'hC0DE);
  endtask

  task automatic t_softreset;
    logic [15:0] v;
    wr_cmd(1, 0, 16'h0140);
    rd(1, 0, v); chk("R2 plain store", v, 16'h0140);
    wr_cmd(1, 4, 16'h0001);
    wr_cmd(1, 0, 16'h8000);
    rd(1, 0, v); chk("R2 ctrl reloaded", v, 16'h1000);
    rd(1, 4, v); chk("R2 adv reloaded", v, 16'h01E1);
    rd(1, 7, v); chk("R2 reg7 cleared", v, 16'h0000);
    rd(1, 1, v); chk("R2 status with link", v, 16'h786C);
    rd(1, 5, v); chk("R2 partner with link", v, 16'h01E1);
  endtask

  task automatic t_linkfail;
    logic [15:0] v;
    link_up = 0; wait_cyc(2);
    chk("R9 no scan hold", {15'd0, link_fail}, 16'h0);
    rd(1, 0, v);
    chk("R7 read samples link", {15'd0, link_fail}, 16'h1);
    link_up = 1; wait_cyc(2);
    chk("R9 no scan hold up", {15'd0, link_fail}, 16'h1);
    scan_on = 1;
    strobe(2, 16'h0001);
    chk("R9 scan set no change", {15'd0, link_fail}, 16'h1);
    link_up = 0; wait_cyc(2);
    chk("R9 scan down", {15'd0, link_fail}, 16'h1);
    link_up = 1; @(negedge clk);
    chk("R9 scan up", {15'd0, link_fail}, 16'h0);
    link_up = 0; @(negedge clk);
    chk("R9 scan down again", {15'd0, link_fail}, 16'h1);
    scan_on = 0;
    strobe(2, 16'h0000);
    link_up = 1; wait_cyc(2);
  endtask

  task automatic t_done;
    logic [15:0] v;
    rd(1, 2, v);
    @(negedge clk);
    wr_data = 16'h0100; addr_wr = 1;
    @(negedge clk);
    addr_wr = 0;
    chk("R10 done high", {15'd0, done}, 16'h1);
    @(negedge clk);
    chk("R10 done low", {15'd0, done}, 16'h0);
    strobe(2, 16'h0004);
    strobe(1, 16'h0042);
    chk("R10 rd_data held", rd_data, 16'h2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_link();
    t_readonly();
    t_phyaddr();
    t_wdata();
    t_softreset();
    t_linkfail();
    t_done();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule